// File: doc/BRIEF.md
# DMA Channel Event Pending and Interrupt Controller

This block gathers completion events from two groups of DMA channels, a normal group and a dedicated group with the same number of channels in each. Every channel reports two kinds of event, a half-way mark and an end-of-transfer mark. Each event arrives as a single-cycle pulse and sets a sticky bit in a shared status word. Each group fills one half of that word, and each channel owns two adjacent bits within its half.

Software reaches two registers through a small register port: the pending-status word and an enable word that uses the same layout. Software acknowledges events by writing ones to the pending word. Writing back the value just read therefore clears exactly the events that were seen, and writing all ones discards any stale status. One registered, level-sensitive interrupt line is high while any pending bit has its enable bit set.

Top module: `dma_evt_irq_ctrl`

## Requirements
- R1: Reset (synchronous, active high) clears the pending word and the enable word, and drives `irq` low.
- R2: A half-way pulse on normal channel n sets pending bit 2n. An end pulse on normal channel n sets pending bit 2n+1.
- R3: A half-way pulse on dedicated channel n sets pending bit 16+2n. An end pulse on dedicated channel n sets pending bit 17+2n.
- R4: A pending bit stays set until software clears it, no matter how many idle cycles pass.
- R5: A pending-word write (`reg_sel`=0) clears each bit written as one. Bits written as zero keep their value.
- R6: If an event pulse and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R7: The enable word (`reg_sel`=1) is written with the full data value and reads back unchanged. Events are captured in the pending word even when their enable bit is zero.
- R8: `irq` is high exactly when some bit is set in both the pending word and the enable word. It follows the register update at the same clock edge.
- R9: `reg_rdata` shows, one cycle after the edge, the register that `reg_sel` chose at that edge (0 = pending, 1 = enable), as it stood before that edge's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nrm_half_evt | input | 8 | Half-way pulses, normal channels |
| nrm_end_evt | input | 8 | End-of-transfer pulses, normal channels |
| ded_half_evt | input | 8 | Half-way pulses, dedicated channels |
| ded_end_evt | input | 8 | End-of-transfer pulses, dedicated channels |
| reg_sel | input | 1 | Register select: 0 pending, 1 enable |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
Each of the 32 event sources is pulsed alone. This separates the two groups, the two event kinds and every channel position, because the bench derives the expected bit from the source index. Write-back clears are tried with the exact bit, with zeros and with the complement mask. These patterns tell a correct write-one-to-clear apart from plain overwrite and from inverted masks. For every bit, an all-sources burst with a single enable bit, or with all but one enable bit, shows that the interrupt comes from the pending-and-enable product and not from either word alone. Same-cycle event-and-clear collisions on each bit confirm that the event has priority.

// File: rtl/dma_evt_irq_pkg.sv
package dma_evt_irq_pkg;
  // register select encoding on the register port
  localparam logic SEL_PEND = 1'b0;
  localparam logic SEL_EN   = 1'b1;
  // bits per channel in the status word
  localparam int EVT_KINDS = 2;
endpackage

// File: rtl/dma_evt_pack.sv
module dma_evt_pack #(
  parameter int CH_PER_GROUP = 8,
  localparam int HALF_W = dma_evt_irq_pkg::EVT_KINDS * CH_PER_GROUP,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic [CH_PER_GROUP-1:0] nrm_half,
  input  logic [CH_PER_GROUP-1:0] nrm_end,
  input  logic [CH_PER_GROUP-1:0] ded_half,
  input  logic [CH_PER_GROUP-1:0] ded_end,
  output logic [WORD_W-1:0]       set_vec
);
  for (genvar c = 0; c < CH_PER_GROUP; c++) begin : g_ch
    assign set_vec[2*c]            = nrm_half[c];
    assign set_vec[2*c+1]          = nrm_end[c];
    assign set_vec[HALF_W+2*c]     = ded_half[c];
    assign set_vec[HALF_W+2*c+1]   = ded_end[c];
  end
endmodule

// File: rtl/dma_pend_bank.sv
module dma_pend_bank #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] set_vec,
  input  logic              clr_wr,
  input  logic [WORD_W-1:0] clr_mask,
  output logic [WORD_W-1:0] pend_q,
  output logic [WORD_W-1:0] pend_d
);
  logic [WORD_W-1:0] clr_eff;

  assign clr_eff = clr_wr ? clr_mask : '0;

  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    // event has priority over a same-cycle clear
    assign pend_d[b] = set_vec[b] | (pend_q[b] & ~clr_eff[b]);
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end

  // R4: without a write, no set bit may drop
  p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (!rst && !clr_wr) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R6: every pulsed bit is set one cycle later, write or not
  p_evt_wins_r6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

  // R5: a bit written as one without an event is clear afterwards
  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (!rst && clr_wr) |=> ((pend_q & $past(clr_mask & ~set_vec)) == '0));
endmodule

// File: rtl/dma_en_reg.sv
module dma_en_reg #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] en_q,
  output logic [WORD_W-1:0] en_d
);
  assign en_d = wr ? wdata : en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_d;
  end

  // R1: reset leaves the enable word empty
  p_reset_r1: assert property (@(posedge clk) rst |=> (en_q == '0));

  // R7: no write, no change
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!rst && !wr) |=> $stable(en_q));
endmodule

// File: rtl/dma_evt_irq_ctrl.sv
module dma_evt_irq_ctrl #(
  parameter int CH_PER_GROUP = 8,
  localparam int WORD_W = 2 * dma_evt_irq_pkg::EVT_KINDS * CH_PER_GROUP
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CH_PER_GROUP-1:0] nrm_half_evt,
  input  logic [CH_PER_GROUP-1:0] nrm_end_evt,
  input  logic [CH_PER_GROUP-1:0] ded_half_evt,
  input  logic [CH_PER_GROUP-1:0] ded_end_evt,
  input  logic                    reg_sel,
  input  logic                    reg_wr,
  input  logic [WORD_W-1:0]       reg_wdata,
  output logic [WORD_W-1:0]       reg_rdata,
  output logic                    irq
);
  import dma_evt_irq_pkg::*;

  logic [WORD_W-1:0] set_vec;
  logic [WORD_W-1:0] pend_q, pend_d;
  logic [WORD_W-1:0] en_q, en_d;
  logic              pend_wr, en_wr;

  assign pend_wr = reg_wr && (reg_sel == SEL_PEND);
  assign en_wr   = reg_wr && (reg_sel == SEL_EN);

  dma_evt_pack #(.CH_PER_GROUP(CH_PER_GROUP)) u_pack (
    .nrm_half (nrm_half_evt),
    .nrm_end  (nrm_end_evt),
    .ded_half (ded_half_evt),
    .ded_end  (ded_end_evt),
    .set_vec  (set_vec)
  );

  dma_pend_bank #(.WORD_W(WORD_W)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .set_vec  (set_vec),
    .clr_wr   (pend_wr),
    .clr_mask (reg_wdata),
    .pend_q   (pend_q),
    .pend_d   (pend_d)
  );

  dma_en_reg #(.WORD_W(WORD_W)) u_en (
    .clk   (clk),
    .rst   (rst),
    .wr    (en_wr),
    .wdata (reg_wdata),
    .en_q  (en_q),
    .en_d  (en_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      irq       <= |(pend_d & en_d);
      reg_rdata <= (reg_sel == SEL_EN) ? en_q : pend_q;
    end
  end

  // R8: the interrupt line agrees with the stored words
  p_irq_match_r8: assert property (@(posedge clk) disable iff (rst)
    irq == |(pend_q & en_q));

  // R1: reset drops the interrupt
  p_irq_reset_r1: assert property (@(posedge clk) rst |=> !irq);
endmodule

// File: tb/dma_evt_irq_ctrl_test.sv
module dma_evt_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] nh = '0, ne = '0, dh = '0, de = '0;
  logic reg_sel = 1'b0, reg_wr = 1'b0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic irq;

  int checks = 0, errors = 0;
  bit finished = 0;

  dma_evt_irq_ctrl #(.CH_PER_GROUP(NCH)) uut (
    .clk(clk), .rst(rst),
    .nrm_half_evt(nh), .nrm_end_evt(ne), .ded_half_evt(dh), .ded_end_evt(de),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: events from mask (bit 2c/2c+1 normal, 16+2c/17+2c dedicated)
  task automatic cyc(input logic [W-1:0] evt, input logic wr, input logic sel,
                     input logic [W-1:0] data);
    for (int c = 0; c < NCH; c++) begin
      nh[c] = evt[2*c];
      ne[c] = evt[2*c+1];
      dh[c] = evt[16+2*c];
      de[c] = evt[17+2*c];
    end
    reg_wr = wr; reg_sel = sel; reg_wdata = data;
    @(posedge clk); @(negedge clk);
    nh = '0; ne = '0; dh = '0; de = '0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [W-1:0] v);
    cyc('0, 1'b0, sel, '0);
    v = reg_rdata;
  endtask

  logic [W-1:0] v;
  logic [W-1:0] m;

  initial begin
    @(negedge clk); @(negedge clk);
    // R1: reset state, with events pulsing during reset
    cyc('1, 1'b1, 1'b1, '1);
    chk("R1 irq", {31'd0, irq}, '0);
    rst = 1'b0;
    rd(1'b0, v); chk("R1 pending", v, '0);
    rd(1'b1, v); chk("R1 enable", v, '0);
    chk("R1 irq after", {31'd0, irq}, '0);

    // R7: enable write/readback
    cyc('0, 1'b1, 1'b1, 32'hA5C3_0F96);
    rd(1'b1, v); chk("R7 enable readback", v, 32'hA5C3_0F96);
    cyc('0, 1'b1, 1'b1, '1);

    // R2/R3/R5/R8/R9: single-source sweep
    for (int b = 0; b < W; b++) begin
      m = 32'h1 << b;
      cyc(m, 1'b0, 1'b0, '0);
      chk(b < 16 ? "R8 irq on normal event" : "R8 irq on dedicated event", {31'd0, irq}, 1);
      rd(1'b0, v); chk(b < 16 ? "R2 normal bit position" : "R3 dedicated bit position", v, m);
      cyc('0, 1'b1, 1'b0, '0);
      rd(1'b0, v); chk("R5 zero write keeps", v, m);
      cyc('0, 1'b1, 1'b0, ~m);
      rd(1'b0, v); chk("R5 complement write keeps", v, m);
      cyc('0, 1'b1, 1'b0, m);
      rd(1'b0, v); chk("R5 one write clears", v, '0);
      chk("R8 irq drops", {31'd0, irq}, '0);
    end

    // R7/R4: capture with everything disabled, then sticky
    cyc('0, 1'b1, 1'b1, '0);
    cyc('1, 1'b0, 1'b0, '0);
    chk("R8 irq masked", {31'd0, irq}, '0);
    repeat (6) cyc('0, 1'b0, 1'b0, '0);
    rd(1'b0, v); chk("R7 captured while disabled / R4 sticky", v, '1);
    rd(1'b1, v); chk("R9 select enable", v, '0);

    // R8: per-bit enable product
    for (int b = 0; b < W; b++) begin
      m = 32'h1 << b;
      cyc('1, 1'b0, 1'b0, '0);
      cyc('0, 1'b1, 1'b0, ~m);          // leave only bit b pending
      cyc('0, 1'b1, 1'b1, ~m);
      chk("R8 other enables only", {31'd0, irq}, '0);
      cyc('0, 1'b1, 1'b1, m);
      chk("R8 matching enable", {31'd0, irq}, 1);
      cyc('0, 1'b1, 1'b1, '0);
      chk("R8 enable removed", {31'd0, irq}, '0);
    end
    cyc('0, 1'b1, 1'b0, '1);

    // R6: event and clear collide on bit b; bit b^1 is cleared alongside
    for (int b = 0; b < W; b++) begin
      m = 32'h1 << b;
      cyc(m ^ (32'h1 << (b ^ 1)), 1'b0, 1'b0, '0);
      cyc(m, 1'b1, 1'b0, m | (32'h1 << (b ^ 1)));
      rd(1'b0, v); chk("R6 event wins", v, m);
      cyc('0, 1'b1, 1'b0, '1);
      rd(1'b0, v); chk("R5 write-all-ones flush", v, '0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule